// File: doc/BRIEF.md
# Parallel Port Enhanced-Mode Cycle Sequencer

This block is the host side of an enhanced parallel port. It runs single-byte handshake cycles on a peripheral. There are four cycle kinds: address write, data write, address read and data read. A request side takes the cycle kind and a write byte. It answers each cycle with a one-cycle response that carries the byte read and an error flag. The error flag separates a cycle that completed from one that the watchdog cut short. On the pin side the block drives an active-low write line, an active-low address strobe and an active-low data strobe. It drives or releases the 8-bit data bus and samples the peripheral's active-low wait line through a two-flop synchroniser.

A mode input chooses between two wait handshakes. In the newer handshake a cycle only opens its strobe once wait is low, and it closes when wait returns high. In the older handshake the strobe opens at once, and the cycle only closes after wait has been seen going low and then high again. A watchdog counts system clocks from the acceptance of each cycle. When the count reaches a parameterised limit (the count of clocks in about 10 us, for example 500 at 50 MHz), it aborts the cycle, returns an error response and sets a sticky timeout status bit.

While no cycle runs, every pin follows the standard-port control inputs, and the bus direction follows their direction bit.

Top module: `parCycleEngine`

## Requirements
- R1: `reqType` bit 1 selects read (1) or write (0), and bit 0 selects data (1) or address (0). An address cycle drives `pinAddrStrbN` low and keeps `pinDataStrbN` high. A data cycle does the reverse.
- R2: During a write cycle `pinWriteN` is 0, `pinDataOe` is 1 and `pinDataOut` carries the request byte, from acceptance to completion. During a read cycle `pinWriteN` is 1 and `pinDataOe` is 0. A completed read returns on `rspRdData` the value of `pinDataIn` sampled when the cycle closes.
- R3: With `modeNew` = 1, neither strobe goes low while the peripheral holds wait high. The strobe goes low only after wait has been seen low.
- R4: With `modeNew` = 1, a started cycle completes once the synchronised wait is high again. The response is a single-cycle `rspValid` pulse with `rspErr` = 0.
- R5: With `modeNew` = 0, the strobe is low in the cycle after acceptance, whatever the level of wait. The cycle does not complete while wait stays high before it has been seen low.
- R6: A cycle that has not completed by the clock edge `TIMEOUT_CYC` cycles after its acceptance edge is aborted at that edge. `rspValid` is then 1 with `rspErr` = 1, and the pins return to the idle state of R8.
- R7: An abort sets `statTimeout`. The bit stays set until a `statRdEn` pulse, or a `statWrEn` pulse with `statWrBit0` = 1, clears it. A `statWrEn` pulse with `statWrBit0` = 0 leaves it set.
- R8: While no cycle runs, `pinWriteN`, `pinAddrStrbN`, `pinDataStrbN` and `pinDataOut` equal `sppWriteN`, `sppAStrbN`, `sppDStrbN` and `sppData`, and `pinDataOe` equals the inverse of `sppDirIn`.
- R9: After reset `reqReady` is 1, `rspValid` is 0 and `statTimeout` is 0. `reqReady` is 0 from acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeNew | input | 1 | 1: newer wait handshake, 0: older handshake |
| reqValid | input | 1 | Start a cycle (taken when reqReady is 1) |
| reqType | input | 2 | Cycle kind: bit 1 read, bit 0 data |
| reqWrData | input | 8 | Byte for write cycles |
| reqReady | output | 1 | Sequencer idle |
| rspValid | output | 1 | One-cycle response pulse |
| rspErr | output | 1 | Response is an abort |
| rspRdData | output | 8 | Byte returned by a read cycle |
| statWrEn | input | 1 | Status write pulse |
| statWrBit0 | input | 1 | Status write value for bit 0 (1 clears) |
| statRdEn | input | 1 | Status read pulse (clears timeout) |
| statTimeout | output | 1 | Sticky timeout status bit |
| sppWriteN | input | 1 | Idle level of the write line |
| sppDStrbN | input | 1 | Idle level of the data strobe |
| sppAStrbN | input | 1 | Idle level of the address strobe |
| sppDirIn | input | 1 | Idle bus direction, 1 = input |
| sppData | input | 8 | Idle bus output byte |
| pinWriteN | output | 1 | Active-low write line |
| pinDataStrbN | output | 1 | Active-low data strobe |
| pinAddrStrbN | output | 1 | Active-low address strobe |
| pinDataOut | output | 8 | Bus output byte |
| pinDataOe | output | 1 | Bus output enable |
| pinDataIn | input | 8 | Bus input byte |
| pinWaitN | input | 1 | Asynchronous active-low wait from the peripheral |

## Verification
Random cycles draw the kind, the handshake mode, the bytes and the wait delays. Because every kind runs in both modes, the checks can separate an address strobe from a data strobe, a driven bus from a released one, and a returned read byte from a stale one. In the newer mode, wait is held high for a random hold-off first, which separates a sequencer that waits for wait low from one that opens at once. In the older mode, wait stays high after the strobe opens, which catches a sequencer that closes on the level instead of on the low-then-high edge. Hung cycles, where wait never rises, check the exact abort cycle, the error response, the release of the pins and each way the status bit can be cleared or left alone.

// File: rtl/parCyclePkg.sv
package parCyclePkg;

  // bit 1: read, bit 0: data strobe
  typedef enum logic [1:0] {
    CYC_ADDR_WR = 2'b00,
    CYC_DATA_WR = 2'b01,
    CYC_ADDR_RD = 2'b10,
    CYC_DATA_RD = 2'b11
  } cycKind_t;

  typedef struct packed {
    logic accept;    // request taken this cycle
    logic busy;      // a cycle owns the pins
    logic strobeOn;  // strobe phase active
    logic finish;    // normal completion this cycle
    logic abort;     // watchdog abort this cycle
  } seqCtl_t;

endpackage

// File: rtl/parCycleCtrl.sv
module parCycleCtrl
  import parCyclePkg::*;
#(
  parameter int TIMEOUT_CYC = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeNew,
  input  logic    reqValid,
  input  logic    waitNAsync,
  output logic    reqReady,
  output seqCtl_t ctl
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_STRB} seqState_t;

  seqState_t state;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0] cnt;
  logic modeQ;
  logic sawLow;
  logic waitHigh;
  logic done;
  logic timeUp;
  logic abortNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], waitNAsync};
  end

  assign waitHigh = syncQ[SYNC_STAGES-1];
  assign timeUp   = (cnt == CNT_LAST);
  assign done     = (state == ST_STRB) && waitHigh && (modeQ || sawLow);
  assign abortNow = (state != ST_IDLE) && timeUp && !done;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      modeQ  <= 1'b0;
      sawLow <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state  <= modeNew ? ST_ARM : ST_STRB;
            modeQ  <= modeNew;
            cnt    <= '0;
            sawLow <= 1'b0;
          end
        end
        ST_ARM: begin
          cnt <= cnt + 1'b1;
          if (abortNow)       state <= ST_IDLE;
          else if (!waitHigh) state <= ST_STRB;
        end
        ST_STRB: begin
          cnt <= cnt + 1'b1;
          if (!waitHigh) sawLow <= 1'b1;
          if (done || abortNow) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady     = (state == ST_IDLE);
  assign ctl.accept   = (state == ST_IDLE) && reqValid;
  assign ctl.busy     = (state != ST_IDLE);
  assign ctl.strobeOn = (state == ST_STRB);
  assign ctl.finish   = done;
  assign ctl.abort    = abortNow;

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (cnt < CNT_W'(TIMEOUT_CYC)));

  // R5
  old_needs_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && !modeQ) |-> sawLow);

  // R3
  new_holdoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ARM) && waitHigh && !timeUp) |=> (state == ST_ARM));

endmodule

// File: rtl/parCycleDatapath.sv
module parCycleDatapath
  import parCyclePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [1:0]        reqType,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdData,
  input  logic              statWrEn,
  input  logic              statWrBit0,
  input  logic              statRdEn,
  output logic              statTimeout,
  input  logic              sppWriteN,
  input  logic              sppDStrbN,
  input  logic              sppAStrbN,
  input  logic              sppDirIn,
  input  logic [DATA_W-1:0] sppData,
  output logic              pinWriteN,
  output logic              pinDataStrbN,
  output logic              pinAddrStrbN,
  output logic [DATA_W-1:0] pinDataOut,
  output logic              pinDataOe,
  input  logic [DATA_W-1:0] pinDataIn
);

  cycKind_t          kindQ;
  logic [DATA_W-1:0] wrQ;
  logic              isRead;
  logic              isData;

  assign isRead = kindQ[1];
  assign isData = kindQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ <= CYC_ADDR_WR;
      wrQ   <= '0;
    end else if (ctl.accept) begin
      kindQ <= cycKind_t'(reqType);
      wrQ   <= reqWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspErr    <= 1'b0;
      rspRdData <= '0;
    end else begin
      rspValid <= ctl.finish || ctl.abort;
      if (ctl.finish || ctl.abort) begin
        rspErr    <= ctl.abort;
        rspRdData <= (ctl.finish && isRead) ? pinDataIn : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 statTimeout <= 1'b0;
    else if (ctl.abort)                        statTimeout <= 1'b1;
    else if (statRdEn || (statWrEn && statWrBit0)) statTimeout <= 1'b0;
  end

  always_comb begin
    if (ctl.busy) begin
      pinWriteN    = isRead;
      pinAddrStrbN = !(ctl.strobeOn && !isData);
      pinDataStrbN = !(ctl.strobeOn && isData);
      pinDataOut   = wrQ;
      pinDataOe    = !isRead;
    end else begin
      pinWriteN    = sppWriteN;
      pinAddrStrbN = sppAStrbN;
      pinDataStrbN = sppDStrbN;
      pinDataOut   = sppData;
      pinDataOe    = !sppDirIn;
    end
  end

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R7
  timeout_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.abort |=> statTimeout);

  // R6
  abort_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (!ctl.strobeOn || $past(ctl.accept)));

  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |-> (pinAddrStrbN || pinDataStrbN));

endmodule

// File: rtl/parCycleEngine.sv
module parCycleEngine
  import parCyclePkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeNew,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdData,
  input  logic              statWrEn,
  input  logic              statWrBit0,
  input  logic              statRdEn,
  output logic              statTimeout,
  input  logic              sppWriteN,
  input  logic              sppDStrbN,
  input  logic              sppAStrbN,
  input  logic              sppDirIn,
  input  logic [DATA_W-1:0] sppData,
  output logic              pinWriteN,
  output logic              pinDataStrbN,
  output logic              pinAddrStrbN,
  output logic [DATA_W-1:0] pinDataOut,
  output logic              pinDataOe,
  input  logic [DATA_W-1:0] pinDataIn,
  input  logic              pinWaitN
);

  seqCtl_t ctl;

  parCycleCtrl #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeNew   (modeNew),
    .reqValid  (reqValid),
    .waitNAsync(pinWaitN),
    .reqReady  (reqReady),
    .ctl       (ctl)
  );

  parCycleDatapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqType     (reqType),
    .reqWrData   (reqWrData),
    .rspValid    (rspValid),
    .rspErr      (rspErr),
    .rspRdData   (rspRdData),
    .statWrEn    (statWrEn),
    .statWrBit0  (statWrBit0),
    .statRdEn    (statRdEn),
    .statTimeout (statTimeout),
    .sppWriteN   (sppWriteN),
    .sppDStrbN   (sppDStrbN),
    .sppAStrbN   (sppAStrbN),
    .sppDirIn    (sppDirIn),
    .sppData     (sppData),
    .pinWriteN   (pinWriteN),
    .pinDataStrbN(pinDataStrbN),
    .pinAddrStrbN(pinAddrStrbN),
    .pinDataOut  (pinDataOut),
    .pinDataOe   (pinDataOe),
    .pinDataIn   (pinDataIn)
  );

endmodule

// File: tb/parCycleEngine_tb.sv
module parCycleEngine_tb;

  localparam int LIM = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeNew = 1'b0, reqValid = 1'b0;
  logic [1:0] reqType = 2'b00;
  logic [7:0] reqWrData = 8'h00;
  logic reqReady, rspValid, rspErr, statTimeout;
  logic [7:0] rspRdData;
  logic statWrEn = 1'b0, statWrBit0 = 1'b0, statRdEn = 1'b0;
  logic sppWriteN = 1'b1, sppDStrbN = 1'b1, sppAStrbN = 1'b1, sppDirIn = 1'b0;
  logic [7:0] sppData = 8'h00;
  logic pinWriteN, pinDataStrbN, pinAddrStrbN, pinDataOe;
  logic [7:0] pinDataOut;
  logic [7:0] pinDataIn = 8'h00;
  logic pinWaitN = 1'b1;

  int nRun = 0;
  int nFail = 0;
  int cyc;
  bit gotRsp;
  int rspAt;
  bit gErr;
  logic [7:0] gData;

  always #10 clk = ~clk;

  parCycleEngine #(.TIMEOUT_CYC(LIM)) u_dut (
    .clk(clk), .rstN(rstN), .modeNew(modeNew), .reqValid(reqValid),
    .reqType(reqType), .reqWrData(reqWrData), .reqReady(reqReady),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdData(rspRdData),
    .statWrEn(statWrEn), .statWrBit0(statWrBit0), .statRdEn(statRdEn),
    .statTimeout(statTimeout), .sppWriteN(sppWriteN), .sppDStrbN(sppDStrbN),
    .sppAStrbN(sppAStrbN), .sppDirIn(sppDirIn), .sppData(sppData),
    .pinWriteN(pinWriteN), .pinDataStrbN(pinDataStrbN),
    .pinAddrStrbN(pinAddrStrbN), .pinDataOut(pinDataOut),
    .pinDataOe(pinDataOe), .pinDataIn(pinDataIn), .pinWaitN(pinWaitN)
  );

  task automatic chk(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected strobe levels while the strobe phase is on
  function automatic logic expAddrN(logic [1:0] k); return k[0]; endfunction
  function automatic logic expDataN(logic [1:0] k); return !k[0]; endfunction
  function automatic logic expWriteN(logic [1:0] k); return k[1]; endfunction
  function automatic logic [7:0] expRd(logic [1:0] k, logic [7:0] rd);
    return k[1] ? rd : 8'h00;
  endfunction

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (rspValid && !gotRsp) begin
      gotRsp = 1'b1;
      rspAt  = cyc;
      gErr   = rspErr;
      gData  = rspRdData;
    end
  endtask

  task automatic chkIdle(string tag);
    chk({tag, " R8 writeN"}, pinWriteN, sppWriteN);
    chk({tag, " R8 addrStrb"}, pinAddrStrbN, sppAStrbN);
    chk({tag, " R8 dataStrb"}, pinDataStrbN, sppDStrbN);
    chk({tag, " R8 dataOut"}, pinDataOut, sppData);
    chk({tag, " R8 oe"}, pinDataOe, !sppDirIn);
  endtask

  task automatic doCycle(bit mode, logic [1:0] kind, logic [7:0] wr,
                         logic [7:0] rd, int d0, int d1, bit hang);
    @(negedge clk);
    sppWriteN = 1'b1; sppAStrbN = 1'b1; sppDStrbN = 1'b1;
    sppDirIn = 1'($urandom); sppData = 8'($urandom);
    modeNew = mode; pinDataIn = rd; pinWaitN = 1'b1;
    reqType = kind; reqWrData = wr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0; gotRsp = 1'b0; rspAt = -1; gErr = 1'b0; gData = 8'h00;
    chk("R9 busy ready", reqReady, 0);
    chk("R2 writeN at start", pinWriteN, expWriteN(kind));
    chk("R2 oe", pinDataOe, !kind[1]);
    if (!kind[1]) chk("R2 write byte", pinDataOut, wr);
    if (mode) begin
      chk("R3 no strobe with wait high", {pinAddrStrbN, pinDataStrbN}, 2'b11);
      for (int i = 0; i < d0; i++) begin
        tick();
        chk("R3 holdoff", {pinAddrStrbN, pinDataStrbN, 1'(gotRsp)}, 3'b110);
      end
      pinWaitN = 1'b0;
      while (pinAddrStrbN && pinDataStrbN && cyc < LIM + 5) tick();
      chk("R1 addr strobe new", pinAddrStrbN, expAddrN(kind));
      chk("R1 data strobe new", pinDataStrbN, expDataN(kind));
    end else begin
      chk("R5 addr strobe old", pinAddrStrbN, expAddrN(kind));
      chk("R5 data strobe old", pinDataStrbN, expDataN(kind));
      for (int i = 0; i < d0; i++) tick();
      chk("R5 no finish while wait high", gotRsp, 0);
      pinWaitN = 1'b0;
    end
    chk("R2 writeN in strobe", pinWriteN, expWriteN(kind));
    for (int i = 0; i < d1; i++) tick();
    if (!hang) pinWaitN = 1'b1;
    while (!gotRsp && cyc < LIM + 10) tick();
    chk("R4 response seen", gotRsp, 1);
    chk("R6 error flag", gErr, hang);
    if (hang) begin
      chk("R6 abort cycle", rspAt, LIM);
      chk("R7 timeout set", statTimeout, 1);
    end else begin
      chk("R2 read byte", gData, expRd(kind, rd));
    end
    chk("R9 ready after rsp", reqReady, 1);
    chkIdle("R6 after rsp");
    tick();
    chk("R4 single pulse", rspValid, 0);
    pinWaitN = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    if (hang) begin
      statWrEn = 1'b1; statWrBit0 = 1'b0;
      @(negedge clk); statWrEn = 1'b0;
      chk("R7 write 0 ignored", statTimeout, 1);
      if ($urandom_range(1, 0) == 1) statRdEn = 1'b1;
      else begin statWrEn = 1'b1; statWrBit0 = 1'b1; end
      @(negedge clk); statRdEn = 1'b0; statWrEn = 1'b0; statWrBit0 = 1'b0;
      chk("R7 cleared", statTimeout, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1284));
    repeat (3) @(negedge clk);
    chk("R9 reset ready", reqReady, 1);
    chk("R9 reset rsp", rspValid, 0);
    chk("R9 reset status", statTimeout, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      sppWriteN = 1'($urandom); sppAStrbN = 1'($urandom);
      sppDStrbN = 1'($urandom); sppDirIn = 1'($urandom);
      sppData = 8'($urandom);
      @(negedge clk);
      chkIdle("idle");
    end
    // directed: each kind in each mode, then a hang in each mode
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 4; k++)
        doCycle(1'(m), 2'(k), 8'hA5 ^ 8'(k), 8'h3C + 8'(k), 3, 4, 1'b0);
    doCycle(1'b1, 2'b11, 8'h00, 8'h77, 0, 2, 1'b1);
    doCycle(1'b0, 2'b00, 8'hFF, 8'h00, 5, 2, 1'b1);
    doCycle(1'b1, 2'b10, 8'h00, 8'h81, 0, 2, 1'b0);
    // random mix
    for (int i = 0; i < 40; i++)
      doCycle(1'($urandom), 2'($urandom), 8'($urandom), 8'($urandom),
              $urandom_range(12, 0), $urandom_range(12, 2),
              $urandom_range(5, 0) == 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule